// File: doc/BRIEF.md
# Device Cache Coherence Line Controller

This block keeps the coherence state of a few cachelines that a device caches from host memory. It serves read, write and evict commands from the device core. When a command needs permission from the host, it sends a device-to-host request: a shared read, an ownership read, a dirty evict or a clean evict. It answers host snoops and installs lines when the host returns a completion that grants a state. Each way has four coherence states (I=0, S=1, E=2, M=3), a line tag and a one-beat data register. Lines are addressed by the 46-bit line address, which is physical address bits 51..6 of a 64-byte line.

Only one request can wait for the host at a time. It is held in a single tracker. While it waits, and in any cycle that carries a snoop, the core is told to hold its command. A snoop that reaches the line of the waiting request is answered from the state the line has already committed. A completion and a snoop can arrive in the same cycle. The completion is applied first, and the snoop then sees the line as the completion left it.

Top module: `dev_line_ctrl`

## Requirements
- R1: After reset every way is Invalid, no output valid is raised, `core_busy` is low, and a snoop to any address answers state I without data.
- R2: A core read (op 0) that misses sends request op 1 (shared read) for the command's line address one cycle later and holds `core_busy` high. One cycle after the completion, `core_done` pulses with the completion data, and the line holds the granted state (S=1 or E=2).
- R3: A core read that hits pulses `core_done` one cycle later with the stored data and sends no request.
- R4: A core write (op 1) to an Invalid or Shared line sends request op 2 (ownership read) and waits. When the completion grants ownership, the line takes the write data and becomes M.
- R5: A core write to an E or M line sends no request. One cycle later it pulses `core_done`, and the line becomes M with the new data.
- R6: Snoop kind 0 (invalidate) leaves the line Invalid and answers state I. It returns the line data, with the data flag set, exactly when the line was M.
- R7: Snoop kind 1 (share) leaves a present line Shared and answers state S. It returns the data exactly when the line was M.
- R8: Snoop kind 2 (current) leaves the state unchanged and answers that state. It returns the data exactly when the line is M.
- R9: A snoop response appears exactly one cycle after every snoop. A snoop that misses answers I without data.
- R10: A core evict (op 2) of an M line sends op 3 (dirty evict) carrying the line data. Evicting an E or S line sends op 4 (clean evict). Either way the line becomes I, and the evict of a line that is not present sends nothing. All three pulse `core_done`.
- R11: When a completion and a snoop to the same line arrive in one cycle, the snoop is answered from the state the completion installs.
- R12: While a request waits, a snoop to its line is answered from the committed state, no second request is issued, and `core_busy` stays high.
- R13: A read or write miss with every way valid pulses `core_refused`, sends no request and leaves the lines unchanged.
- R14: A core command presented together with a snoop is ignored: `core_busy` is high, and neither `core_done` nor a request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core command present |
| core_op | input | 2 | 0 read, 1 write, 2 evict, 3 no operation |
| core_addr | input | 46 | Line address of the command |
| core_wdata | input | 512 | Full-line write data |
| core_busy | output | 1 | Command cannot be taken this cycle |
| core_done | output | 1 | Command finished |
| core_refused | output | 1 | Miss rejected, no free way |
| core_rdata | output | 512 | Read data (write data for writes) |
| d2h_valid | output | 1 | Device-to-host request valid |
| d2h_op | output | 3 | 1 shared read, 2 ownership read, 3 dirty evict, 4 clean evict |
| d2h_addr | output | 46 | Request line address |
| d2h_data | output | 512 | Evicted data for dirty evict |
| cmp_valid | input | 1 | Host completion for the waiting request |
| cmp_state | input | 2 | Granted state (S or E) |
| cmp_data | input | 512 | Line data for a shared read |
| snp_valid | input | 1 | Host snoop present |
| snp_kind | input | 2 | 0 invalidate, 1 share, 2 current |
| snp_addr | input | 46 | Snooped line address |
| snp_rsp_valid | output | 1 | Snoop response valid |
| snp_rsp_state | output | 2 | State of the line after the snoop |
| snp_rsp_has_data | output | 1 | Response carries dirty data |
| snp_rsp_data | output | 512 | Dirty line data |

## Verification
Two functions can act in the same cycle here: a host completion that installs a line, and a host snoop to that same line. The bench makes this happen by leaving a shared read, or an ownership read, waiting, and then driving `cmp_valid` and `snp_valid` on one clock edge. It judges the outcome by the snoop response. After an exclusive grant, a share snoop must answer S with no data. After an ownership grant, an invalidate snoop must answer I and return the freshly written data. A core command that collides with a snoop is checked the same way, at the ports.

// File: rtl/dev_line_ctrl.sv
module dev_line_ctrl #(
  parameter int WAYS   = 4,
  parameter int LA_W   = 46,
  parameter int DATA_W = 512,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_valid,
  input  logic [1:0]        core_op,
  input  logic [LA_W-1:0]   core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_busy,
  output logic              core_done,
  output logic              core_refused,
  output logic [DATA_W-1:0] core_rdata,
  output logic              d2h_valid,
  output logic [2:0]        d2h_op,
  output logic [LA_W-1:0]   d2h_addr,
  output logic [DATA_W-1:0] d2h_data,
  input  logic              cmp_valid,
  input  logic [1:0]        cmp_state,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [LA_W-1:0]   snp_addr,
  output logic              snp_rsp_valid,
  output logic [1:0]        snp_rsp_state,
  output logic              snp_rsp_has_data,
  output logic [DATA_W-1:0] snp_rsp_data
);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [2:0] OP_RDS = 3'd1, OP_RDO = 3'd2, OP_DEV = 3'd3, OP_CEV = 3'd4;

  logic [1:0]        st   [WAYS];
  logic [1:0]        st_n [WAYS];
  logic [LA_W-1:0]   tg   [WAYS];
  logic [LA_W-1:0]   tg_n [WAYS];
  logic [DATA_W-1:0] dt   [WAYS];
  logic [DATA_W-1:0] dt_n [WAYS];

  logic              pend, pend_n, own, own_n;
  logic [WAY_W-1:0]  twy, twy_n;
  logic [LA_W-1:0]   tad, tad_n;
  logic [DATA_W-1:0] twd, twd_n;

  logic              done_n, ref_n, dv_n, sv_n, shd_n;
  logic [DATA_W-1:0] rd_n, dd_n, sd_n;
  logic [2:0]        dop_n;
  logic [LA_W-1:0]   da_n;
  logic [1:0]        sst_n;

  logic              c_hit, f_ok, s_hit;
  logic [WAY_W-1:0]  c_way, f_way, s_way;

  assign core_busy = pend | snp_valid;

  always_comb begin
    st_n = st; tg_n = tg; dt_n = dt;
    pend_n = pend; own_n = own; twy_n = twy; tad_n = tad; twd_n = twd;
    done_n = 1'b0; ref_n = 1'b0; rd_n = '0;
    dv_n = 1'b0; dop_n = '0; da_n = '0; dd_n = '0;
    sv_n = 1'b0; sst_n = ST_I; shd_n = 1'b0; sd_n = '0;

    if (pend && cmp_valid) begin
      st_n[twy] = own ? ST_M : cmp_state;
      tg_n[twy] = tad;
      dt_n[twy] = own ? twd : cmp_data;
      pend_n = 1'b0;
      done_n = 1'b1;
      rd_n   = own ? twd : cmp_data;
    end

    s_hit = 1'b0; s_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (!s_hit && st_n[w] != ST_I && tg_n[w] == snp_addr) begin
        s_hit = 1'b1; s_way = WAY_W'(w);
      end
    if (snp_valid) begin
      sv_n = 1'b1;
      if (s_hit) begin
        shd_n = (st_n[s_way] == ST_M);
        sd_n  = shd_n ? dt_n[s_way] : '0;
        case (snp_kind)
          2'd0:    st_n[s_way] = ST_I;
          2'd1:    st_n[s_way] = ST_S;
          default: ;
        endcase
        sst_n = st_n[s_way];
      end
    end

    c_hit = 1'b0; c_way = '0; f_ok = 1'b0; f_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!c_hit && st[w] != ST_I && tg[w] == core_addr) begin
        c_hit = 1'b1; c_way = WAY_W'(w);
      end
      if (!f_ok && st[w] == ST_I) begin
        f_ok = 1'b1; f_way = WAY_W'(w);
      end
    end
    if (core_valid && !core_busy) begin
      case (core_op)
        2'd0: if (c_hit) begin
                done_n = 1'b1; rd_n = dt[c_way];
              end else if (f_ok) begin
                dv_n = 1'b1; dop_n = OP_RDS; da_n = core_addr;
                pend_n = 1'b1; own_n = 1'b0; twy_n = f_way; tad_n = core_addr;
              end else ref_n = 1'b1;
        2'd1: if (c_hit && st[c_way][1]) begin
                st_n[c_way] = ST_M; dt_n[c_way] = core_wdata;
                done_n = 1'b1; rd_n = core_wdata;
              end else if (c_hit || f_ok) begin
                dv_n = 1'b1; dop_n = OP_RDO; da_n = core_addr;
                pend_n = 1'b1; own_n = 1'b1; twy_n = c_hit ? c_way : f_way;
                tad_n = core_addr; twd_n = core_wdata;
              end else ref_n = 1'b1;
        2'd2: begin
                done_n = 1'b1;
                if (c_hit) begin
                  dv_n = 1'b1; da_n = core_addr;
                  dop_n = (st[c_way] == ST_M) ? OP_DEV : OP_CEV;
                  dd_n  = (st[c_way] == ST_M) ? dt[c_way] : '0;
                  st_n[c_way] = ST_I;
                end
              end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) st[w] <= ST_I;
      pend <= 1'b0; own <= 1'b0; twy <= '0; tad <= '0; twd <= '0;
      core_done <= 1'b0; core_refused <= 1'b0; core_rdata <= '0;
      d2h_valid <= 1'b0; d2h_op <= '0; d2h_addr <= '0; d2h_data <= '0;
      snp_rsp_valid <= 1'b0; snp_rsp_state <= ST_I;
      snp_rsp_has_data <= 1'b0; snp_rsp_data <= '0;
    end else begin
      st <= st_n;
      pend <= pend_n; own <= own_n; twy <= twy_n; tad <= tad_n; twd <= twd_n;
      core_done <= done_n; core_refused <= ref_n; core_rdata <= rd_n;
      d2h_valid <= dv_n; d2h_op <= dop_n; d2h_addr <= da_n; d2h_data <= dd_n;
      snp_rsp_valid <= sv_n; snp_rsp_state <= sst_n;
      snp_rsp_has_data <= shd_n; snp_rsp_data <= sd_n;
    end
  end

  always_ff @(posedge clk) begin
    tg <= tg_n;
    dt <= dt_n;
  end

  assert_snoop_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> snp_rsp_valid);

  assert_inval_ends_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_kind == 2'd0) |=> snp_rsp_state == ST_I);

  assert_data_only_if_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_rsp_has_data |-> (snp_rsp_state != ST_E));

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> !d2h_valid);

  assert_read_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (d2h_valid && (d2h_op == OP_RDS || d2h_op == OP_RDO)) |-> core_busy);

  assert_done_xor_refused_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_done && core_refused));

  assert_snoop_blocks_core_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !pend && !$past(pend)) |=> !d2h_valid);
endmodule

// File: tb/dev_line_ctrl_test.sv
module dev_line_ctrl_test;
  localparam int PERIOD = 10;
  localparam int LA_W = 46, DW = 512;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
  localparam logic [1:0] K_INV = 2'd0, K_DAT = 2'd1, K_CUR = 2'd2;

  localparam logic [6:0] VEC [12] = '{
    {SI, K_INV, SI, 1'b0}, {SI, K_DAT, SI, 1'b0}, {SI, K_CUR, SI, 1'b0},
    {SS, K_INV, SI, 1'b0}, {SS, K_DAT, SS, 1'b0}, {SS, K_CUR, SS, 1'b0},
    {SE, K_INV, SI, 1'b0}, {SE, K_DAT, SS, 1'b0}, {SE, K_CUR, SE, 1'b0},
    {SM, K_INV, SI, 1'b1}, {SM, K_DAT, SS, 1'b1}, {SM, K_CUR, SM, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic core_valid = 1'b0; logic [1:0] core_op = '0;
  logic [LA_W-1:0] core_addr = '0; logic [DW-1:0] core_wdata = '0;
  logic core_busy, core_done, core_refused; logic [DW-1:0] core_rdata;
  logic d2h_valid; logic [2:0] d2h_op; logic [LA_W-1:0] d2h_addr; logic [DW-1:0] d2h_data;
  logic cmp_valid = 1'b0; logic [1:0] cmp_state = '0; logic [DW-1:0] cmp_data = '0;
  logic snp_valid = 1'b0; logic [1:0] snp_kind = '0; logic [LA_W-1:0] snp_addr = '0;
  logic snp_rsp_valid; logic [1:0] snp_rsp_state; logic snp_rsp_has_data; logic [DW-1:0] snp_rsp_data;

  int n_chk = 0, n_bad = 0;
  logic c_done, c_ref, c_dv, c_sv, c_shd;
  logic [2:0] c_dop; logic [1:0] c_sst; logic [LA_W-1:0] c_da;
  logic [DW-1:0] c_rd, c_dd, c_sd;

  dev_line_ctrl uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [7:0] b);
    return {64{b}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cap;
    @(negedge clk);
    c_done = core_done; c_ref = core_refused; c_rd = core_rdata;
    c_dv = d2h_valid; c_dop = d2h_op; c_da = d2h_addr; c_dd = d2h_data;
    c_sv = snp_rsp_valid; c_sst = snp_rsp_state; c_shd = snp_rsp_has_data; c_sd = snp_rsp_data;
  endtask

  task automatic core(input logic [1:0] op, input logic [LA_W-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    core_valid = 1'b1; core_op = op; core_addr = a; core_wdata = d;
    cap;
    core_valid = 1'b0;
  endtask

  task automatic cmpl(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_state = s; cmp_data = d;
    cap;
    cmp_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] k, input logic [LA_W-1:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = k; snp_addr = a;
    cap;
    snp_valid = 1'b0;
  endtask

  task automatic install(input logic [1:0] s, input logic [LA_W-1:0] a, input logic [DW-1:0] d);
    if (s == SS || s == SE) begin
      core(2'd0, a, '0); cmpl(s, d);
    end else if (s == SM) begin
      core(2'd1, a, d); cmpl(SE, '0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!core_done && !d2h_valid && !snp_rsp_valid && !core_busy, "R1 idle outputs",
        {core_done, d2h_valid, snp_rsp_valid, core_busy}, 0);
    snoop(K_CUR, 46'h55);
    chk(c_sv && c_sst == SI && !c_shd, "R1 snoop after reset", {c_sv, c_sst, c_shd}, 4'b1000);

    for (int i = 0; i < 12; i++) begin
      logic [LA_W-1:0] a;
      a = 46'h100 + LA_W'(i);
      install(VEC[i][6:5], a, pat(8'(8'h20 + i)));
      snoop(VEC[i][4:3], a);
      chk(c_sv, "R9 response one cycle after snoop", c_sv, 1);
      chk(c_sst == VEC[i][2:1], "R6/R7/R8 snoop result state", c_sst, VEC[i][2:1]);
      chk(c_shd == VEC[i][0], "R6/R7/R8 data flag", c_shd, VEC[i][0]);
      if (VEC[i][0])
        chk(c_sd == pat(8'(8'h20 + i)), "R6/R7/R8 dirty data", c_sd[63:0], pat(8'(8'h20 + i)) >> 448);
      snoop(K_INV, a);
    end

    core(2'd0, 46'h200, '0);
    chk(c_dv && c_dop == 3'd1 && c_da == 46'h200, "R2 shared read request", {c_dv, c_dop, c_da}, {1'b1, 3'd1, 46'h200});
    chk(core_busy, "R2 busy while waiting", core_busy, 1);
    cmpl(SS, pat(8'hA1));
    chk(c_done && c_rd == pat(8'hA1), "R2 fill done with data", {c_done, c_rd[7:0]}, 9'h1A1);
    snoop(K_CUR, 46'h200);
    chk(c_sst == SS, "R2 granted state installed", c_sst, SS);
    core(2'd0, 46'h200, '0);
    chk(c_done && !c_dv && c_rd == pat(8'hA1), "R3 read hit", {c_done, c_dv, c_rd[7:0]}, 10'h2A1);

    core(2'd1, 46'h200, pat(8'hB2));
    chk(c_dv && c_dop == 3'd2, "R4 ownership request from S", {c_dv, c_dop}, 4'b1010);
    snoop(K_CUR, 46'h200);
    chk(c_sst == SS && !c_shd && !c_dv, "R12 snoop on pending line uses committed state", {c_sst, c_shd, c_dv}, {SS, 2'b00});
    core(2'd0, 46'h201, '0);
    chk(!c_dv && !c_done && core_busy, "R12 no second request while waiting", {c_dv, c_done, core_busy}, 3'b001);
    cmpl(SE, '0);
    chk(c_done, "R4 write done after grant", c_done, 1);
    snoop(K_CUR, 46'h200);
    chk(c_sst == SM && c_shd && c_sd == pat(8'hB2), "R4 line M with write data", {c_sst, c_shd, c_sd[7:0]}, {SM, 1'b1, 8'hB2});

    install(SE, 46'h300, pat(8'h11));
    core(2'd1, 46'h300, pat(8'hC3));
    chk(c_done && !c_dv, "R5 silent write to E", {c_done, c_dv}, 2'b10);
    snoop(K_CUR, 46'h300);
    chk(c_sst == SM && c_sd == pat(8'hC3), "R5 line M after silent write", {c_sst, c_sd[7:0]}, {SM, 8'hC3});

    core(2'd2, 46'h300, '0);
    chk(c_dv && c_dop == 3'd3 && c_dd == pat(8'hC3) && c_done, "R10 dirty evict carries data", {c_dv, c_dop, c_dd[7:0]}, {1'b1, 3'd3, 8'hC3});
    snoop(K_CUR, 46'h300);
    chk(c_sst == SI && !c_shd, "R10 evicted line invalid", {c_sst, c_shd}, 3'b000);
    core(2'd2, 46'h200, '0);
    chk(c_dv && c_dop == 3'd3, "R10 dirty evict of written line", {c_dv, c_dop}, 4'b1011);
    install(SE, 46'h301, pat(8'h12));
    core(2'd2, 46'h301, '0);
    chk(c_dv && c_dop == 3'd4 && c_done, "R10 clean evict of E", {c_dv, c_dop, c_done}, 5'b11001);
    core(2'd2, 46'h302, '0);
    chk(c_done && !c_dv, "R10 evict miss sends nothing", {c_done, c_dv}, 2'b10);

    core(2'd0, 46'h400, '0);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_state = SE; cmp_data = pat(8'hD4);
    snp_valid = 1'b1; snp_kind = K_DAT; snp_addr = 46'h400;
    cap;
    cmp_valid = 1'b0; snp_valid = 1'b0;
    chk(c_sv && c_sst == SS && !c_shd && c_done, "R11 completion E then share snoop", {c_sv, c_sst, c_shd, c_done}, {1'b1, SS, 2'b01});
    core(2'd1, 46'h401, pat(8'hE5));
    @(negedge clk);
    cmp_valid = 1'b1; cmp_state = SE; cmp_data = '0;
    snp_valid = 1'b1; snp_kind = K_INV; snp_addr = 46'h401;
    cap;
    cmp_valid = 1'b0; snp_valid = 1'b0;
    chk(c_sst == SI && c_shd && c_sd == pat(8'hE5), "R11 ownership then invalidate returns data", {c_sst, c_shd, c_sd[7:0]}, {SI, 1'b1, 8'hE5});

    @(negedge clk);
    core_valid = 1'b1; core_op = 2'd0; core_addr = 46'h500;
    snp_valid = 1'b1; snp_kind = K_CUR; snp_addr = 46'h999;
    #1 chk(core_busy, "R14 busy with snoop", core_busy, 1);
    cap;
    core_valid = 1'b0; snp_valid = 1'b0;
    chk(!c_done && !c_dv && c_sv, "R14 command ignored", {c_done, c_dv, c_sv}, 3'b001);

    install(SS, 46'h600, pat(8'h01));
    install(SS, 46'h601, pat(8'h02));
    install(SS, 46'h602, pat(8'h03));
    core(2'd1, 46'h603, pat(8'h04));
    cmpl(SE, '0);
    core(2'd0, 46'h604, '0);
    chk(c_ref && !c_dv && !c_done, "R13 full array refuses read miss", {c_ref, c_dv, c_done}, 3'b100);
    core(2'd1, 46'h605, pat(8'h06));
    chk(c_ref && !c_dv, "R13 full array refuses write miss", {c_ref, c_dv}, 2'b10);
    core(2'd0, 46'h601, '0);
    chk(c_done && c_rd == pat(8'h02), "R13 lines unchanged", {c_done, c_rd[7:0]}, 9'h102);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule